// File: doc/BRIEF.md
# Sliding-Correlation PRBS Synchronizer and Error Counter

This block sits behind the data and recovered clock of a receiver under test, one received bit per clock. Out of reset it fills a local code table from a maximal-length LFSR, then replays that table against the incoming stream. It counts how many bits agree over each full code period. When a period ends with too little agreement, the read phase of the table moves one chip later. This is repeated until the agreement count exceeds a threshold supplied on an input. The block then raises `sync`.

While locked, the block counts every bit where the received and local values differ, in windows of two code periods. It closes each window with a one-cycle `err_done` pulse and a held `err_count`. The agreement test keeps running on every period. A period that fails drops `sync`, fires a one-cycle `alarm` and restarts acquisition. The surrounding system turns the counts and alarms into reports.

Top module: `bert_slide_sync`

## Requirements
- R1: After reset the block spends P = 2^LFSR_W - 1 clocks filling its table, with `sync` low, and ignores `rx_bit` during that time. The table holds the chip sequence c[0..P-1]. It is given by c[k] = 1 for k < LFSR_W and c[n+LFSR_W] = c[n] XOR c[n+LFSR_W-1-LFSR_TAP]. The default (9, 4) gives the polynomial x^9 + x^4 + 1.
- R2: Run cycle t (t = 0 on the (P+1)-th clock edge after reset release) compares `rx_bit` with c[(t mod P + offset) mod P]. The offset starts at 0. Each period of P run cycles counts the bits that agree, and the count restarts from zero at every period.
- R3: At the last cycle of a period, the count including that cycle's bit is tested against `thr` with a strict greater-than. A pass leaves `sync` high from the following cycle.
- R4: A failed period while `sync` is low advances the offset by one, modulo P. A phase shift of d chips is therefore found at the end of period d, which is clock edge (d+2)·P after reset release.
- R5: While `sync` is high, the offset does not change.
- R6: A failed period while `sync` is high clears `sync`. The offset is kept, so a stream that has not moved relocks after one more period.
- R7: `alarm` is a one-cycle pulse in the cycle after a failed period that ended with `sync` high. It is never raised during acquisition.
- R8: Error windows start with the first period after `sync` rises and span two periods, back to back. Each window counts the bits where `rx_bit` XOR the local chip is 1, including the window's last bit. `err_done` pulses for one cycle after the window's last edge, and `err_count` holds the total until the next pulse.
- R9: A window that contains a failed period produces no `err_done`. Its partial count is discarded.
- R10: During and right after reset, `sync`, `alarm` and `err_done` are low and `err_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received data bit, one per clock |
| thr | input | $clog2(P+1) | Agreement threshold, strict greater-than |
| sync | output | 1 | Local code aligned with the stream |
| alarm | output | 1 | One-cycle pulse on loss of alignment |
| err_done | output | 1 | One-cycle pulse closing an error window |
| err_count | output | $clog2(2P+1) | Mismatch total of the last closed window |

## Verification
The bench builds the block with LFSR_W = 5 and LFSR_TAP = 2, which gives a 31-chip code. With this short code a full offset sweep, a slip of several chips and many back-to-back windows all fit in a short run, and the lock edge can be predicted exactly. A threshold of 24 puts the strict-comparison boundary between 6 and 7 errors per period. The bench can therefore show that one period keeps lock while the next one loses it. Misaligned phases of this sequence agree on 15 chips, so every wrong offset fails.

// File: rtl/bert_slide_pkg.sv
package bert_slide_pkg;

  // Number of chips in one period of a maximal sequence of width w.
  function automatic int unsigned seq_len(input int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // One shift of the Fibonacci register: output on the top bit, feedback into bit 0.
  function automatic logic [31:0] lfsr_next(input logic [31:0] s,
                                            input int unsigned w,
                                            input int unsigned tap);
    logic fb;
    fb = s[w-1] ^ s[tap];
    return ((s << 1) | {31'd0, fb}) & ((32'd1 << w) - 32'd1);
  endfunction

  // (a + b) mod p for a, b < p.
  function automatic logic [31:0] wrap_add(input logic [31:0] a,
                                           input logic [31:0] b,
                                           input int unsigned p);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, p}) s = s - {1'b0, p};
    return s[31:0];
  endfunction

endpackage

// File: rtl/prbs_table.sv
module prbs_table
  import bert_slide_pkg::*;
#(
  parameter int W   = 9,
  parameter int TAP = 4,
  parameter int P   = 511,
  parameter int AW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          ready
);

  logic [W-1:0]  lfsr_q;
  logic [AW-1:0] fill_q;
  logic          ready_q;
  logic [P-1:0]  tab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= '1;
      fill_q  <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      lfsr_q <= W'(lfsr_next(32'(lfsr_q), W, TAP));
      if (fill_q == AW'(P - 1)) ready_q <= 1'b1;
      else fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!ready_q) tab_q[fill_q] <= lfsr_q[W-1];
  end

  assign rd_bit = tab_q[rd_addr];
  assign ready  = ready_q;

  // R1: the fill runs once per reset and never restarts
  assert_fill_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q);

endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import bert_slide_pkg::*;
#(
  parameter int P  = 511,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          slide,
  output logic          bnd,
  output logic [AW-1:0] off,
  output logic [AW-1:0] rd_addr
);

  logic [AW-1:0] acc_q;
  logic [AW-1:0] off_q;

  assign bnd = run && (acc_q == AW'(P - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      off_q <= '0;
    end else if (run) begin
      acc_q <= bnd ? '0 : acc_q + 1'b1;
      if (bnd && slide) off_q <= (off_q == AW'(P - 1)) ? '0 : off_q + 1'b1;
    end
  end

  assign rd_addr = AW'(wrap_add(32'(acc_q), 32'(off_q), P));
  assign off     = off_q;

  // R2: phase and offset stay inside one period
  assert_phase_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q < AW'(P)) && (off_q < AW'(P)));

  // R4: the offset only moves on a period boundary
  assert_slide_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> $past(bnd));

endmodule

// File: rtl/corr_track.sv
module corr_track #(
  parameter int SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bnd,
  input  logic          rx_bit,
  input  logic          loc_bit,
  input  logic [SW-1:0] thr,
  output logic          sync,
  output logic          alarm,
  output logic          pass,
  output logic          slide
);

  logic [SW-1:0] sum_q;
  logic [SW-1:0] total;
  logic          agree;
  logic          sync_q;
  logic          alarm_q;

  assign agree = ~(rx_bit ^ loc_bit);
  assign total = sum_q + SW'(agree);
  assign pass  = total > thr;
  assign slide = bnd && !pass && !sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      sync_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= 1'b0;
      if (run) begin
        if (bnd) begin
          sum_q   <= '0;
          sync_q  <= pass;
          alarm_q <= sync_q && !pass;
        end else begin
          sum_q <= total;
        end
      end
    end
  end

  assign sync  = sync_q;
  assign alarm = alarm_q;

  // R7: an alarm only marks the cycle right after sync fell
  assert_alarm_on_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> (!sync_q && $past(sync_q)));

  // R3: sync changes only after a period boundary
  assert_sync_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q != $past(sync_q)) |-> $past(bnd));

endmodule

// File: rtl/err_window.sv
module err_window #(
  parameter int P  = 511,
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          bnd,
  input  logic          pass,
  input  logic          sync,
  input  logic          miss,
  output logic          done,
  output logic [EW-1:0] count
);

  logic          active_q;
  logic          half_q;
  logic [EW-1:0] err_q;
  logic [EW-1:0] err_nxt;
  logic          done_q;
  logic [EW-1:0] count_q;

  assign err_nxt = err_q + EW'(miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      err_q    <= '0;
      done_q   <= 1'b0;
      count_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (run) begin
        if (bnd) begin
          if (pass && sync && active_q) begin
            if (half_q) begin
              done_q  <= 1'b1;
              count_q <= err_nxt;
              err_q   <= '0;
              half_q  <= 1'b0;
            end else begin
              err_q  <= err_nxt;
              half_q <= 1'b1;
            end
          end else if (pass) begin
            active_q <= 1'b1;
            half_q   <= 1'b0;
            err_q    <= '0;
          end else begin
            active_q <= 1'b0;
            half_q   <= 1'b0;
            err_q    <= '0;
          end
        end else if (active_q) begin
          err_q <= err_nxt;
        end
      end
    end
  end

  assign done  = done_q;
  assign count = count_q;

  // R8: a window closes only while lock is held
  assert_done_while_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> sync);

  // R8: the running count never exceeds two periods of bits
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= EW'(2 * P));

  // R9: counting runs only while locked, so a dropped window cannot close
  assert_active_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !bnd && run) |-> sync);

endmodule

// File: rtl/bert_slide_sync.sv
module bert_slide_sync
  import bert_slide_pkg::*;
#(
  parameter int LFSR_W   = 9,
  parameter int LFSR_TAP = 4,
  localparam int P  = (1 << LFSR_W) - 1,
  localparam int AW = LFSR_W,
  localparam int SW = $clog2(P + 1),
  localparam int EW = $clog2(2 * P + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  input  logic [SW-1:0] thr,
  output logic          sync,
  output logic          alarm,
  output logic          err_done,
  output logic [EW-1:0] err_count
);

  logic          run;
  logic          bnd;
  logic          slide;
  logic          pass;
  logic          loc_bit;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] off;

  prbs_table #(.W(LFSR_W), .TAP(LFSR_TAP), .P(P), .AW(AW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rd_addr),
    .rd_bit  (loc_bit),
    .ready   (run)
  );

  phase_gen #(.P(P), .AW(AW)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .slide   (slide),
    .bnd     (bnd),
    .off     (off),
    .rd_addr (rd_addr)
  );

  corr_track #(.SW(SW)) u_corr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .bnd     (bnd),
    .rx_bit  (rx_bit),
    .loc_bit (loc_bit),
    .thr     (thr),
    .sync    (sync),
    .alarm   (alarm),
    .pass    (pass),
    .slide   (slide)
  );

  err_window #(.P(P), .EW(EW)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .bnd   (bnd),
    .pass  (pass),
    .sync  (sync),
    .miss  (rx_bit ^ loc_bit),
    .done  (err_done),
    .count (err_count)
  );

  // R5: the offset is frozen while locked
  assert_offset_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> $stable(off));

  // R6: a drop and a window close never share a cycle
  assert_exclusive_pulses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_done, alarm}));

  // R1: no lock is claimed while the table is filling
  assert_no_sync_in_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sync);

endmodule

// File: tb/bert_slide_sync_tb.sv
module bert_slide_sync_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 5;
  localparam int TAP = 2;
  localparam int P   = (1 << W) - 1;
  localparam int SW  = $clog2(P + 1);
  localparam int EW  = $clog2(2 * P + 1);
  localparam int THR = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_bit = 1'b0;
  logic [SW-1:0] thr = SW'(THR);
  logic          sync;
  logic          alarm;
  logic          err_done;
  logic [EW-1:0] err_count;

  bert_slide_sync #(.LFSR_W(W), .LFSR_TAP(TAP)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_bit    (rx_bit),
    .thr       (thr),
    .sync      (sync),
    .alarm     (alarm),
    .err_done  (err_done),
    .err_count (err_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int chip [P];
  int edge_n    = 0;
  int shift_d   = 5;
  int n_chk     = 0;
  int n_bad     = 0;
  int alarm_cnt = 0;
  int done_cnt  = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive the bit for the next edge, clock once, then sample at the falling edge.
  task automatic step(input bit flip);
    int idx;
    idx = (((edge_n + 1) - (P + 1) + shift_d) % P + P) % P;
    rx_bit = 1'(chip[idx]) ^ flip;
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    if (alarm) alarm_cnt++;
    if (err_done) done_cnt++;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R10 sync in reset", int'(sync), 0);
    check("R10 alarm in reset", int'(alarm), 0);
    check("R10 done in reset", int'(err_done), 0);
    check("R10 count in reset", int'(err_count), 0);
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  task automatic t_fill;
    int highs = 0;
    for (int i = 0; i < P; i++) begin
      step(1'b0);
      if (sync) highs++;
    end
    check("R1 sync low during fill", highs, 0);
  endtask

  task automatic t_acquire;
    int highs = 0;
    while (edge_n < (shift_d + 2) * P - 1) begin
      step(1'b0);
      if (sync) highs++;
    end
    check("R4 no lock before slide count reached", highs, 0);
    check("R7 no alarm during acquisition", alarm_cnt, 0);
    step(1'b0);
    check("R3 R1 lock at edge (d+2)P", int'(sync), 1);
  endtask

  task automatic t_window(input int first_flips, input bit flip_last, input int exp, input string req);
    int d0;
    d0 = done_cnt;
    for (int i = 1; i <= 2 * P; i++) begin
      step((i <= first_flips) || (flip_last && i == 2 * P));
      if (i == P) check({req, " lock kept at mid window"}, int'(sync), 1);
      if (i == 2 * P - 1) check({req, " no early done"}, done_cnt - d0, 0);
    end
    check({req, " done pulse"}, int'(err_done), 1);
    check({req, " error count"}, int'(err_count), exp);
  endtask

  task automatic t_drop;
    int d0;
    d0 = done_cnt;
    for (int i = 1; i <= P; i++) step(i <= 7);
    check("R6 sync dropped on 7 errors", int'(sync), 0);
    check("R7 alarm pulse on drop", int'(alarm), 1);
    step(1'b0);
    check("R7 alarm lasts one cycle", int'(alarm), 0);
    for (int i = 2; i <= P; i++) step(1'b0);
    check("R6 relock with offset kept", int'(sync), 1);
    check("R9 aborted window gives no done", done_cnt - d0, 0);
  endtask

  task automatic t_slip;
    shift_d = (shift_d + 3) % P;
    repeat (P) step(1'b0);
    check("R6 slip drops sync", int'(sync), 0);
    check("R7 alarm on slip", int'(alarm), 1);
    repeat (3 * P) step(1'b0);
    check("R4 still sliding", int'(sync), 0);
    repeat (P) step(1'b0);
    check("R4 relock after three slides", int'(sync), 1);
    check("R7 total alarms", alarm_cnt, 2);
  endtask

  initial begin
    for (int k = 0; k < W; k++) chip[k] = 1;
    for (int n = 0; n + W < P; n++) chip[n + W] = chip[n] ^ chip[n + W - 1 - TAP];
    t_reset();
    t_fill();
    t_acquire();
    t_window(3, 1'b0, 3, "R8 three leading errors");
    t_window(0, 1'b0, 0, "R8 R5 count cleared");
    t_window(1, 1'b1, 2, "R8 last bit counted");
    t_window(6, 1'b0, 6, "R3 R2 six errors keep lock");
    t_drop();
    t_slip();
    t_window(0, 1'b0, 0, "R5 clean after slip");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", edge_n, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule